// File: doc/BRIEF.md
# Corner Image Reconstructor

This block turns a binary corner image back into the binary layout image it was derived from. Each corner pixel marks a spot where the image changes, measured both along the row and down the column. Corner pixels arrive in raster order, one per valid cycle, with markers for the first pixel of each row and of each frame. The block emits the rebuilt layout pixel one cycle later, with the same markers.

The block keeps two pieces of state. A single flag holds the horizontal fill of the current row, and it toggles on every corner pixel equal to 1. A row of status bits, one per column, records whether that column is inside a vertical run. The output pixel is the column's status bit XOR the fill flag, and that result is written back as the column's status for the next row. No shape or line drawing logic is needed, and the only storage is one bit per column. The row width is a parameter. A row that is cut short is flagged as a framing error.

Top module: `corner_recon`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, out_valid, out_pixel, out_row_start, out_frame_start and out_frame_err are all 0.
- R2: Every accepted beat (in_valid=1) produces exactly one output beat one clock later. out_valid goes high in the cycle after in_valid. out_row_start is the registered OR of in_row_start and in_frame_start, and out_frame_start is the registered in_frame_start.
- R3: The horizontal fill flag is forced to 0 on a beat with in_row_start=1 or in_frame_start=1, before that beat's corner bit is applied. An in_corner of 1 toggles the flag and an in_corner of 0 leaves it unchanged.
- R4: For the pixel at column x, out_pixel equals the column's stored status XOR the updated fill flag. That same value replaces the column's status for the next row.
- R5: A beat with in_frame_start=1 makes every column status read as 0 for the whole first row of the new frame, whatever the previous frame left behind.
- R6: Cycles with in_valid=0 change no state. Their in_corner, in_row_start and in_frame_start values have no effect, and they produce out_valid=0 with all other outputs 0.
- R7: A beat with in_row_start=1 and in_frame_start=0 that arrives after fewer than WIDTH pixels of the current row raises out_frame_err on that beat's output cycle only. A full row, or a frame start, raises no error.
- R8: Feeding the corner image of any binary image gives back that image bit for bit. This holds for rectangles, width-1 lines, single pixels and shapes touching the image edges. The corner image is defined with out-of-image pixels taken as 0, and corner(x,y) = I(x-1,y-1) ^ I(x,y-1) ^ I(x-1,y) ^ I(x,y).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A corner beat is present |
| in_corner | input | 1 | Corner pixel value |
| in_row_start | input | 1 | Beat is the first pixel of a row |
| in_frame_start | input | 1 | Beat is the first pixel of a frame (also starts a row) |
| out_valid | output | 1 | Reconstructed pixel is present |
| out_pixel | output | 1 | Reconstructed layout pixel |
| out_row_start | output | 1 | Output pixel begins a row |
| out_frame_start | output | 1 | Output pixel begins a frame |
| out_frame_err | output | 1 | Row start arrived before the previous row was complete |

## Verification
The bench builds random rectangle images and hand-made shapes: width-1 lines, single pixels, full edge rows and an empty frame. It computes their corner images and compares every rebuilt pixel against the original. One frame leaves its bottom row filled and is followed by an all-zero corner frame; a design that failed to clear the column status at a frame start would print stripes down that second frame. Idle cycles are inserted mid-row with corner and row-start held high, which catches a design that lets invalid cycles reset the fill or the column count, since the rest of the row would shift or invert. A deliberately short row must raise the framing error exactly once, on the following row start, and no other beat may raise it.

// File: rtl/corner_recon_pkg.sv
package corner_recon_pkg;

    typedef struct packed {
        logic valid;
        logic corner;
        logic row_start;
        logic frame_start;
    } corner_beat_t;

    typedef struct packed {
        logic valid;
        logic pixel;
        logic row_start;
        logic frame_start;
        logic frame_err;
    } pixel_beat_t;

    function automatic logic toggle(input logic cur, input logic flip);
        return cur ^ flip;
    endfunction

    function automatic logic opens_row(input corner_beat_t b);
        return b.row_start | b.frame_start;
    endfunction

endpackage

// File: rtl/cr_col_tracker.sv
module cr_col_tracker
    import corner_recon_pkg::*;
#(
    parameter int WIDTH = 64
) (
    input  logic                     clk,
    input  logic                     rst,
    input  corner_beat_t             beat,
    output logic [$clog2(WIDTH)-1:0] col_addr,
    output logic                     col_ok,
    output logic                     blank_rd,
    output logic                     early_row
);
    localparam int AW = $clog2(WIDTH);
    localparam int CW = $clog2(WIDTH + 1);
    localparam logic [CW-1:0] FULL = CW'(WIDTH);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] pos;
    logic          first_row_q;

    always_comb begin
        pos       = opens_row(beat) ? '0 : cnt_q;
        col_ok    = pos < FULL;
        col_addr  = pos[AW-1:0];
        early_row = beat.valid & beat.row_start & ~beat.frame_start & (cnt_q < FULL);
        blank_rd  = beat.frame_start | (first_row_q & ~beat.row_start);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q       <= '0;
            first_row_q <= 1'b1;
        end else if (beat.valid) begin
            cnt_q <= col_ok ? pos + 1'b1 : FULL;
            if (beat.frame_start)
                first_row_q <= 1'b1;
            else if (beat.row_start)
                first_row_q <= 1'b0;
        end
    end

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !beat.valid |=> $stable(cnt_q) && $stable(first_row_q));

    // R5
    frame_blank_chk: assert property (@(posedge clk) disable iff (rst)
        beat.valid && beat.frame_start |=> first_row_q);

    // R7
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= FULL);

endmodule

// File: rtl/cr_fill_track.sv
module cr_fill_track
    import corner_recon_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  corner_beat_t beat,
    output logic         fill_now
);
    logic fill_q;

    always_comb begin
        fill_now = toggle(opens_row(beat) ? 1'b0 : fill_q, beat.corner);
    end

    always_ff @(posedge clk) begin
        if (rst)
            fill_q <= 1'b0;
        else if (beat.valid)
            fill_q <= fill_now;
    end

    // R3
    fill_hold_chk: assert property (@(posedge clk) disable iff (rst)
        beat.valid && !beat.corner && !opens_row(beat) |=> fill_q == $past(fill_q));

    // R3
    row_open_chk: assert property (@(posedge clk) disable iff (rst)
        beat.valid && opens_row(beat) |=> fill_q == $past(beat.corner));

endmodule

// File: rtl/cr_column_store.sv
module cr_column_store #(
    parameter int WIDTH = 64
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [$clog2(WIDTH)-1:0] addr,
    input  logic                     wdata,
    output logic                     rdata
);
    logic [WIDTH-1:0] status_q;

    always_comb begin
        rdata = status_q[addr];
    end

    always_ff @(posedge clk) begin
        if (rst)
            status_q <= '0;
        else if (we)
            status_q[addr] <= wdata;
    end

    // R4
    store_write_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> status_q[$past(addr)] == $past(wdata));

endmodule

// File: rtl/corner_recon.sv
module corner_recon
    import corner_recon_pkg::*;
#(
    parameter int WIDTH = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic in_corner,
    input  logic in_row_start,
    input  logic in_frame_start,
    output logic out_valid,
    output logic out_pixel,
    output logic out_row_start,
    output logic out_frame_start,
    output logic out_frame_err
);
    localparam int AW = $clog2(WIDTH);

    corner_beat_t    beat;
    pixel_beat_t     out_q;
    logic [AW-1:0]   col_addr;
    logic            col_ok;
    logic            blank_rd;
    logic            early_row;
    logic            fill_now;
    logic            rdata;
    logic            status_old;
    logic            status_new;

    always_comb begin
        beat.valid       = in_valid;
        beat.corner      = in_corner;
        beat.row_start   = in_row_start;
        beat.frame_start = in_frame_start;
    end

    cr_col_tracker #(.WIDTH(WIDTH)) u_cols (
        .clk       (clk),
        .rst       (rst),
        .beat      (beat),
        .col_addr  (col_addr),
        .col_ok    (col_ok),
        .blank_rd  (blank_rd),
        .early_row (early_row)
    );

    cr_fill_track u_fill (
        .clk      (clk),
        .rst      (rst),
        .beat     (beat),
        .fill_now (fill_now)
    );

    always_comb begin
        status_old = (blank_rd | ~col_ok) ? 1'b0 : rdata;
        status_new = toggle(status_old, fill_now);
    end

    cr_column_store #(.WIDTH(WIDTH)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (in_valid & col_ok),
        .addr  (col_addr),
        .wdata (status_new),
        .rdata (rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.valid       <= in_valid;
            out_q.pixel       <= in_valid & status_new;
            out_q.row_start   <= in_valid & opens_row(beat);
            out_q.frame_start <= in_valid & in_frame_start;
            out_q.frame_err   <= early_row;
        end
    end

    assign out_valid       = out_q.valid;
    assign out_pixel       = out_q.pixel;
    assign out_row_start   = out_q.row_start;
    assign out_frame_start = out_q.frame_start;
    assign out_frame_err   = out_q.frame_err;

    // R2
    lat_on_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R6
    lat_off_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid && !out_pixel && !out_frame_err);

    // R7
    err_marker_chk: assert property (@(posedge clk) disable iff (rst)
        out_frame_err |-> out_valid && out_row_start && !out_frame_start);

endmodule

// File: tb/corner_recon_bench.sv
`timescale 1ns/1ps
module corner_recon_bench;
    localparam int W = 16;
    localparam int H = 8;

    logic clk = 1'b0;
    logic rst;
    logic in_valid, in_corner, in_row_start, in_frame_start;
    logic out_valid, out_pixel, out_row_start, out_frame_start, out_frame_err;

    int checks = 0;
    int fails  = 0;
    bit img [H][W];
    bit cor [H][W];

    always #2.5 clk = ~clk;

    corner_recon #(.WIDTH(W)) u_corner_recon (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_corner(in_corner),
        .in_row_start(in_row_start), .in_frame_start(in_frame_start),
        .out_valid(out_valid), .out_pixel(out_pixel),
        .out_row_start(out_row_start), .out_frame_start(out_frame_start),
        .out_frame_err(out_frame_err)
    );

    task automatic check(input logic [4:0] act, input logic [4:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual {v,pix,rs,fs,err}=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit px(input int x, input int y);
        if (x < 0 || y < 0) return 1'b0;
        return img[y][x];
    endfunction

    task automatic make_corners();
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++)
                cor[y][x] = px(x-1, y-1) ^ px(x, y-1) ^ px(x-1, y) ^ px(x, y);
    endtask

    task automatic clear_img();
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++)
                img[y][x] = 1'b0;
    endtask

    task automatic add_rect(input int x0, input int y0, input int w, input int h);
        for (int y = y0; y < y0 + h && y < H; y++)
            for (int x = x0; x < x0 + w && x < W; x++)
                img[y][x] = 1'b1;
    endtask

    // one beat in, outputs sampled 1 ns after the capturing edge
    task automatic step(input bit v, input bit c, input bit rs, input bit fs,
                        input logic [4:0] exp, input string req);
        in_valid = v; in_corner = c; in_row_start = rs; in_frame_start = fs;
        @(posedge clk);
        #1;
        check({out_valid, out_pixel, out_row_start, out_frame_start, out_frame_err}, exp, req);
    endtask

    task automatic send_frame(input string req, input int gap_every);
        make_corners();
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++) begin
                step(1'b1, cor[y][x], x == 0, (x == 0 && y == 0),
                     {1'b1, img[y][x], (x == 0), (x == 0 && y == 0), 1'b0}, req);
                if (gap_every > 0 && ((y*W + x) % gap_every) == gap_every - 1)
                    // R6: idle beat with corner and row start held high is ignored
                    step(1'b0, 1'b1, 1'b1, 1'b0, 5'b00000, "R6 idle");
            end
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        in_valid = 0; in_corner = 0; in_row_start = 0; in_frame_start = 0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        // R1: outputs quiet in reset
        check({out_valid, out_pixel, out_row_start, out_frame_start, out_frame_err}, 5'b0, "R1 in reset");
        in_valid = 1; in_corner = 1; in_row_start = 1; in_frame_start = 1;
        @(posedge clk);
        #1;
        check({out_valid, out_pixel, out_row_start, out_frame_start, out_frame_err}, 5'b0, "R1 reset held");
        in_valid = 0; in_corner = 0; in_row_start = 0; in_frame_start = 0;
        rst = 1'b0;
        @(posedge clk);
        #1;
        check({out_valid, out_pixel, out_row_start, out_frame_start, out_frame_err}, 5'b0, "R1 after reset");

        // R2 R3 R4 R8: single pixel and width-1 lines
        clear_img(); img[3][5] = 1'b1;
        send_frame("R8 single pixel", 0);
        clear_img(); add_rect(2, 0, 1, H); add_rect(0, 4, W, 1);
        send_frame("R3 R4 width-1 lines", 0);
        clear_img(); add_rect(0, 0, W, H);
        send_frame("R8 full frame", 0);

        // R5: bottom row filled, then empty corner frame must give zeros
        clear_img(); add_rect(1, 5, 12, 3); add_rect(14, 0, 2, H);
        send_frame("R5 leaves status", 0);
        clear_img();
        send_frame("R5 cleared by frame start", 0);

        // R8 R6: random rectangles, some with idle gaps
        for (int f = 0; f < 24; f++) begin
            clear_img();
            for (int r = 0; r < 1 + (f % 5); r++)
                add_rect($urandom_range(0, W-1), $urandom_range(0, H-1),
                         $urandom_range(1, 6), $urandom_range(1, 4));
            send_frame((f % 3 == 0) ? "R6 R8 gaps" : "R8 random", (f % 3 == 0) ? 7 : 0);
        end

        // R7: short second row on an empty image
        for (int x = 0; x < W; x++)
            step(1, 0, x == 0, x == 0, {1'b1, 1'b0, x == 0, x == 0, 1'b0}, "R7 full row");
        for (int x = 0; x < 5; x++)
            step(1, 0, x == 0, 0, {1'b1, 1'b0, x == 0, 1'b0, 1'b0}, "R7 short row");
        for (int x = 0; x < W; x++)
            step(1, 0, x == 0, 0, {1'b1, 1'b0, x == 0, 1'b0, x == 0}, "R7 early row start");
        for (int x = 0; x < W; x++)
            step(1, 0, x == 0, 0, {1'b1, 1'b0, x == 0, 1'b0, 1'b0}, "R7 full row no err");

        // R7 R8: next frame recovers
        clear_img(); add_rect(3, 2, 4, 3);
        send_frame("R7 R8 after error", 0);
        step(0, 0, 0, 0, 5'b0, "R2 drain");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule